// File: doc/BRIEF.md
# Block Transfer Channel Controller with Memory-Cycle Arbitration

This block runs several block-transfer channels that move words between peripherals and memory without processor involvement. Software loads each channel with a starting word address, a word count and a direction. After that, the peripheral paces the transfer with a request line and, for output, an accepted line. Every completed memory cycle advances the channel's address by one and lowers its remaining count by one. When the count reaches zero, the channel raises end of block toward both the device and the interrupt system.

One fixed-priority arbiter shares the memory among the channels and the processor. Channel 0 ranks highest. The processor gets a cycle only when no channel has a latched request. The arbiter chooses a winner only between memory cycles, and the winner keeps the memory until the memory reports that the cycle is done.

A peripheral can also select a maximum-rate mode for output blocks. In that mode the channel asks for a new memory cycle as soon as the previous one finishes, with no handshake per word.

Top module: `blk_xfer_ctrl`

## Requirements
- R1: When a memory cycle starts for a channel, the winner is the lowest-numbered channel with a latched request, so channel 0 has the highest priority. `mem_chan_gnt` bit i marks channel i as the owner.
- R2: The processor is granted (`cpu_gnt`=1) only when no channel has a latched request. During a processor cycle, `mem_addr` and `mem_rw` come from `cpu_addr` and `cpu_rw`.
- R3: No new cycle starts while `mem_avail` is low. Once a cycle starts, `mem_req` stays high and the owner, `mem_addr` and `mem_rw` hold until the clock edge that samples `mem_done`. Exactly one owner is flagged while `mem_req` is high, and none while it is low.
- R4: During each of its cycles, a channel presents its current word address on `mem_addr`. Every completed cycle increments that address by one and decrements the word count by one.
- R5: In normal mode, a request is latched on a rising edge of `dev_req` (low at one clock edge, high at the next). Edges that arrive while a request is latched or its cycle is running are ignored, and each latched request yields exactly one memory cycle.
- R6: In normal output mode, after each word the channel ignores new request edges until it sees `dev_ack` high at a clock edge.
- R7: `dev_fast` is sampled only at the first latched request of a block. If it was high and the block is an output block, the channel requests again right after each cycle, with no `dev_req` or `dev_ack`, until the count is exhausted. For input blocks it has no effect.
- R8: `mem_rw` is 1 (read/write cycle) for an input block, meaning device to memory, and 0 (read/restore cycle) for an output block, meaning memory to device.
- R9: `eob[i]` goes high at the clock edge that completes the channel's last word. It stays high until the channel is reloaded, and the channel makes no requests while it is high.
- R10: Loading a count of zero sets `eob[i]` at the load edge, and the channel then makes no memory cycle.
- R11: `dev_strobe[i]` pulses for exactly one clock, in the cycle after the clock edge that samples `mem_done` for a channel-i cycle.
- R12: After reset, `mem_req`, `cpu_gnt`, `mem_chan_gnt`, `eob` and `dev_strobe` are all 0, and every channel is idle.
- R13: A load (`ld_sel[i]` high at an edge) sets the address, count and direction (`ld_out`=1 for output) and clears `eob[i]`. A load that arrives while channel i has a latched request or a running cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_sel | input | NCH | One-hot load strobe per channel |
| ld_addr | input | AW | Starting word address to load |
| ld_count | input | CW | Word count to load |
| ld_out | input | 1 | Direction to load: 1 output, 0 input |
| dev_req | input | NCH | Peripheral data transfer request per channel |
| dev_ack | input | NCH | Peripheral data accepted per channel |
| dev_fast | input | NCH | Peripheral maximum-rate select per channel |
| dev_strobe | output | NCH | One-clock word-transferred strobe per channel |
| eob | output | NCH | End of block per channel |
| cpu_req | input | 1 | Processor memory cycle request |
| cpu_addr | input | AW | Processor address |
| cpu_rw | input | 1 | Processor cycle kind |
| cpu_gnt | output | 1 | Processor owns the current memory cycle |
| mem_avail | input | 1 | Memory can start a new cycle |
| mem_done | input | 1 | Memory finished the current cycle |
| mem_req | output | 1 | Memory cycle in progress |
| mem_addr | output | AW | Address of the current cycle |
| mem_rw | output | 1 | 1 read/write, 0 read/restore |
| mem_chan_gnt | output | NCH | One-hot channel owner of the current cycle |

## Verification
The bound assertions check the arbitration invariants on every cycle. These are the priority of the winner at each cycle start, the processor lockout, the holding of owner, address and cycle kind until done, the single-owner rule, the strobe timing and the absence of requests once end of block is set. Other behaviours only show up over a sequence of scenarios in the bench: the edge-only request latching, the output accept handshake, when `dev_fast` is sampled, zero-count loads, loads ignored during a busy cycle, and the exact number of words and the address sequence per block.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    typedef enum logic [2:0] {
        CH_OFF,
        CH_ARM,
        CH_PEND,
        CH_BUSY,
        CH_WAIT_ACK
    } chan_state_e;

    typedef struct packed {
        logic busy;
        logic cpu;
    } arb_state_t;

    localparam logic CYC_READ_WRITE   = 1'b1;
    localparam logic CYC_READ_RESTORE = 1'b0;

    // Next channel state once a memory cycle completes.
    function automatic chan_state_e after_word(input logic last, input logic to_dev,
                                               input logic fast);
        if (last)
            return CH_OFF;
        else if (to_dev && fast)
            return CH_PEND;
        else if (to_dev)
            return CH_WAIT_ACK;
        else
            return CH_ARM;
    endfunction

    function automatic logic cycle_kind(input logic to_dev);
        return to_dev ? CYC_READ_RESTORE : CYC_READ_WRITE;
    endfunction

    function automatic logic may_load(input chan_state_e s);
        return (s != CH_PEND) && (s != CH_BUSY);
    endfunction

endpackage

// File: rtl/blk_xfer_chan.sv
module blk_xfer_chan
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic          ld_out,
    input  logic          dev_req,
    input  logic          dev_ack,
    input  logic          dev_fast,
    input  logic          start,
    input  logic          done,
    output logic          pend,
    output logic [AW-1:0] addr,
    output logic          cyc_rw,
    output logic          strobe,
    output logic          eob
);

    localparam logic [CW-1:0] LAST_WORD = CW'(1);

    chan_state_e   state;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;
    logic          fast_q;
    logic          first_q;
    logic          req_q;
    logic          eob_q;
    logic          strobe_q;
    logic          req_rise;

    assign req_rise = dev_req & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CH_OFF;
            addr_q   <= '0;
            cnt_q    <= '0;
            out_q    <= 1'b0;
            fast_q   <= 1'b0;
            first_q  <= 1'b0;
            req_q    <= 1'b0;
            eob_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            req_q    <= dev_req;
            strobe_q <= 1'b0;
            if (ld && may_load(state)) begin
                addr_q  <= ld_addr;
                cnt_q   <= ld_count;
                out_q   <= ld_out;
                fast_q  <= 1'b0;
                first_q <= 1'b1;
                eob_q   <= (ld_count == '0);
                state   <= (ld_count == '0) ? CH_OFF : CH_ARM;
            end else begin
                unique case (state)
                    CH_ARM: begin
                        if (req_rise) begin
                            state <= CH_PEND;
                            if (first_q) begin
                                fast_q  <= dev_fast;
                                first_q <= 1'b0;
                            end
                        end
                    end
                    CH_PEND: begin
                        if (start) state <= CH_BUSY;
                    end
                    CH_BUSY: begin
                        if (done) begin
                            addr_q   <= addr_q + 1'b1;
                            cnt_q    <= cnt_q - 1'b1;
                            strobe_q <= 1'b1;
                            if (cnt_q == LAST_WORD) eob_q <= 1'b1;
                            state <= after_word(cnt_q == LAST_WORD, out_q, fast_q);
                        end
                    end
                    CH_WAIT_ACK: begin
                        if (dev_ack) state <= CH_ARM;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pend   = (state == CH_PEND);
    assign addr   = addr_q;
    assign cyc_rw = cycle_kind(out_q);
    assign strobe = strobe_q;
    assign eob    = eob_q;

endmodule

// File: rtl/blk_xfer_arb.sv
module blk_xfer_arb
    import blk_xfer_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pend,
    input  logic           cpu_req,
    input  logic           mem_avail,
    input  logic           mem_done,
    output logic [NCH-1:0] start,
    output logic [NCH-1:0] gnt,
    output logic           cpu_gnt,
    output logic           busy
);

    arb_state_t     st;
    logic [NCH-1:0] win;
    logic           free;
    logic           cpu_take;

    // Lowest index wins: scan downward so the last hit is the highest priority.
    always_comb begin
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win    = '0;
                win[i] = 1'b1;
            end
        end
    end

    assign free     = !st.busy && mem_avail;
    assign start    = free ? win : '0;
    assign cpu_take = free && (pend == '0) && cpu_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            gnt <= '0;
        end else if (st.busy) begin
            if (mem_done) begin
                st  <= '0;
                gnt <= '0;
            end
        end else if (start != '0) begin
            st.busy <= 1'b1;
            st.cpu  <= 1'b0;
            gnt     <= start;
        end else if (cpu_take) begin
            st.busy <= 1'b1;
            st.cpu  <= 1'b1;
        end
    end

    assign cpu_gnt = st.cpu;
    assign busy    = st.busy;

endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
    import blk_xfer_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ld_sel,
    input  logic [AW-1:0]  ld_addr,
    input  logic [CW-1:0]  ld_count,
    input  logic           ld_out,
    input  logic [NCH-1:0] dev_req,
    input  logic [NCH-1:0] dev_ack,
    input  logic [NCH-1:0] dev_fast,
    output logic [NCH-1:0] dev_strobe,
    output logic [NCH-1:0] eob,
    input  logic           cpu_req,
    input  logic [AW-1:0]  cpu_addr,
    input  logic           cpu_rw,
    output logic           cpu_gnt,
    input  logic           mem_avail,
    input  logic           mem_done,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rw,
    output logic [NCH-1:0] mem_chan_gnt
);

    logic [NCH-1:0] pend_vec;
    logic [NCH-1:0] start_vec;
    logic [NCH-1:0] gnt_vec;
    logic [NCH-1:0] ch_rw;
    logic [AW-1:0]  ch_addr [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        blk_xfer_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .ld       (ld_sel[g]),
            .ld_addr  (ld_addr),
            .ld_count (ld_count),
            .ld_out   (ld_out),
            .dev_req  (dev_req[g]),
            .dev_ack  (dev_ack[g]),
            .dev_fast (dev_fast[g]),
            .start    (start_vec[g]),
            .done     (mem_done & gnt_vec[g]),
            .pend     (pend_vec[g]),
            .addr     (ch_addr[g]),
            .cyc_rw   (ch_rw[g]),
            .strobe   (dev_strobe[g]),
            .eob      (eob[g])
        );
    end

    blk_xfer_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_vec),
        .cpu_req   (cpu_req),
        .mem_avail (mem_avail),
        .mem_done  (mem_done),
        .start     (start_vec),
        .gnt       (gnt_vec),
        .cpu_gnt   (cpu_gnt),
        .busy      (mem_req)
    );

    // Owner-selected address and cycle kind; the grant vector is one-hot.
    always_comb begin
        mem_addr = cpu_gnt ? cpu_addr : '0;
        mem_rw   = cpu_gnt ? cpu_rw : 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (gnt_vec[i]) begin
                mem_addr = mem_addr | ch_addr[i];
                mem_rw   = mem_rw | ch_rw[i];
            end
        end
    end

    assign mem_chan_gnt = gnt_vec;

endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] pend,
    input logic [NCH-1:0] mem_chan_gnt,
    input logic [NCH-1:0] eob,
    input logic [NCH-1:0] dev_strobe,
    input logic           mem_req,
    input logic           mem_done,
    input logic           cpu_gnt,
    input logic           mem_rw,
    input logic [AW-1:0]  mem_addr
);

    localparam logic [NCH-1:0] ONE = NCH'(1);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1: the new owner was pending and no higher-priority channel was.
    a_r1_highest_wins: assert property (@(posedge clk) disable iff (rst)
        (past_ok && mem_req && !$past(mem_req) && (mem_chan_gnt != '0)) |->
        ((($past(pend) & mem_chan_gnt) != '0) && (($past(pend) & (mem_chan_gnt - ONE)) == '0)));

    // R2: processor wins only with no channel request latched.
    a_r2_cpu_lockout: assert property (@(posedge clk) disable iff (rst)
        (past_ok && cpu_gnt && !$past(cpu_gnt)) |-> ($past(pend) == '0));

    // R3: no preemption within a memory cycle.
    a_r3_hold_owner: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=>
        (mem_req && $stable(mem_chan_gnt) && $stable(cpu_gnt) && $stable(mem_rw) &&
         (cpu_gnt || $stable(mem_addr))));

    // R3: exactly one owner during a cycle, none outside.
    a_r3_one_owner: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_chan_gnt, cpu_gnt}) == (mem_req ? 1 : 0));

    // R9: a channel at end of block never holds a request.
    a_r9_quiet_after_eob: assert property (@(posedge clk) disable iff (rst)
        (eob & pend) == '0);

    // R11: strobe follows the completing edge of that channel's cycle.
    a_r11_strobe_timing: assert property (@(posedge clk) disable iff (rst)
        (dev_strobe != '0) |->
        (past_ok && $past(mem_req && mem_done) && (dev_strobe == $past(mem_chan_gnt))));

endmodule

bind blk_xfer_ctrl blk_xfer_chk #(.NCH(NCH), .AW(AW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .pend         (pend_vec),
    .mem_chan_gnt (mem_chan_gnt),
    .eob          (eob),
    .dev_strobe   (dev_strobe),
    .mem_req      (mem_req),
    .mem_done     (mem_done),
    .cpu_gnt      (cpu_gnt),
    .mem_rw       (mem_rw),
    .mem_addr     (mem_addr)
);

// File: tb/blk_xfer_ctrl_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_ctrl_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 12;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] ld_sel;
    logic [AW-1:0]  ld_addr;
    logic [CW-1:0]  ld_count;
    logic           ld_out;
    logic [NCH-1:0] dev_req, dev_ack, dev_fast;
    logic [NCH-1:0] dev_strobe, eob;
    logic           cpu_req, cpu_rw, cpu_gnt;
    logic [AW-1:0]  cpu_addr;
    logic           mem_avail, mem_done, mem_req, mem_rw;
    logic [AW-1:0]  mem_addr;
    logic [NCH-1:0] mem_chan_gnt;

    always #2.5 clk = ~clk;

    blk_xfer_ctrl #(.NCH(NCH), .AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_count(ld_count),
        .ld_out(ld_out), .dev_req(dev_req), .dev_ack(dev_ack), .dev_fast(dev_fast),
        .dev_strobe(dev_strobe), .eob(eob), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_rw(cpu_rw), .cpu_gnt(cpu_gnt), .mem_avail(mem_avail), .mem_done(mem_done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rw(mem_rw), .mem_chan_gnt(mem_chan_gnt)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [AW-1:0] exp_addr [NCH];
    int            exp_cnt  [NCH];
    bit            exp_rw   [NCH];
    int            xfer_cnt [NCH];
    int            load_cnt [NCH];
    int            grant_seq [64];
    int            gidx = 0;
    bit            hold_lat = 0;
    bit            finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_kind(input bit to_dev);
        return to_dev ? 1'b0 : 1'b1;
    endfunction

    task automatic load_ch(input int ch, input logic [AW-1:0] a, input int c, input bit out);
        @(negedge clk);
        ld_sel = '0; ld_sel[ch] = 1'b1; ld_addr = a; ld_count = CW'(c); ld_out = out;
        @(negedge clk);
        ld_sel = '0;
        exp_addr[ch] = a; exp_cnt[ch] = c; exp_rw[ch] = exp_kind(out);
        xfer_cnt[ch] = 0; load_cnt[ch] = c;
    endtask

    task automatic pulse_req(input logic [NCH-1:0] m);
        @(negedge clk); dev_req = dev_req | m;
        @(negedge clk); dev_req = dev_req & ~m;
    endtask

    task automatic pulse_ack(input logic [NCH-1:0] m);
        @(negedge clk); dev_ack = dev_ack | m;
        @(negedge clk); dev_ack = dev_ack & ~m;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Memory responder and per-cycle monitor.
    initial begin
        int lat;
        int own;
        int done_own;
        bit seen;
        lat = 0; own = 0; done_own = -1; seen = 0;
        mem_done = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (mem_done) begin
                    mem_done = 1'b0;
                    if (done_own >= 0 && done_own < NCH) begin
                        check(dev_strobe[done_own] == 1'b1, "R11 strobe after done",
                              dev_strobe[done_own], 1);
                        check(eob[done_own] == (exp_cnt[done_own] == 0), "R9 eob after word",
                              eob[done_own], (exp_cnt[done_own] == 0));
                    end
                end else if (mem_req) begin
                    if (!seen) begin
                        seen = 1;
                        own = NCH;
                        for (int i = 0; i < NCH; i++) if (mem_chan_gnt[i]) own = i;
                        if (gidx < 64) grant_seq[gidx] = own;
                        gidx++;
                        if (own == NCH) begin
                            check(mem_addr == cpu_addr, "R2 cpu address", mem_addr, cpu_addr);
                            check(mem_rw == cpu_rw, "R2 cpu cycle kind", mem_rw, cpu_rw);
                        end else begin
                            check(mem_addr == exp_addr[own], "R4 word address", mem_addr,
                                  exp_addr[own]);
                            check(mem_rw == exp_rw[own], "R8 cycle kind", mem_rw, exp_rw[own]);
                        end
                        lat = hold_lat ? 4 : $urandom_range(0, 2);
                    end
                    if (lat == 0) begin
                        mem_done = 1'b1;
                        seen = 0;
                        done_own = own;
                        if (own < NCH) begin
                            exp_addr[own] = exp_addr[own] + 1'b1;
                            exp_cnt[own]--;
                            xfer_cnt[own]++;
                        end
                    end else begin
                        lat--;
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; ld_sel = '0; ld_addr = '0; ld_count = '0; ld_out = 1'b0;
        dev_req = '0; dev_ack = '0; dev_fast = '0;
        cpu_req = 1'b0; cpu_addr = 16'h7777; cpu_rw = 1'b1; mem_avail = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            exp_addr[i] = '0; exp_cnt[i] = 0; exp_rw[i] = 0; xfer_cnt[i] = 0; load_cnt[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check(mem_req == 1'b0, "R12 mem_req", mem_req, 0);
        check(cpu_gnt == 1'b0, "R12 cpu_gnt", cpu_gnt, 0);
        check(mem_chan_gnt == '0, "R12 owner", mem_chan_gnt, 0);
        check(eob == '0, "R12 eob", eob, 0);
        check(dev_strobe == '0, "R12 strobe", dev_strobe, 0);

        // R10 zero count
        load_ch(3, 16'h0100, 0, 1'b0);
        check(eob[3] == 1'b1, "R10 eob on zero load", eob[3], 1);
        pulse_req(4'b1000);
        wait_cyc(6);
        check(xfer_cnt[3] == 0, "R10 no transfer", xfer_cnt[3], 0);
        check(mem_req == 1'b0, "R10 memory idle", mem_req, 0);

        // R1 R2 R3 R5 priority, lockout, edge latching
        mem_avail = 1'b0;
        load_ch(2, 16'h0200, 1, 1'b0);
        load_ch(1, 16'h0300, 2, 1'b0);
        pulse_req(4'b0110);
        pulse_req(4'b0010);
        pulse_req(4'b0010);
        cpu_req = 1'b1;
        wait_cyc(3);
        check(mem_req == 1'b0, "R3 no cycle while unavailable", mem_req, 0);
        gidx = 0;
        mem_avail = 1'b1;
        wait_cyc(14);
        cpu_req = 1'b0;
        wait_cyc(8);
        check(grant_seq[0] == 1, "R1 highest first", grant_seq[0], 1);
        check(grant_seq[1] == 2, "R1 next channel", grant_seq[1], 2);
        check(grant_seq[2] == NCH, "R2 cpu after channels", grant_seq[2], NCH);
        check(xfer_cnt[1] == 1, "R5 one cycle per latched edge", xfer_cnt[1], 1);
        check(eob[1] == 1'b0, "R9 eob not yet", eob[1], 0);
        check(eob[2] == 1'b1, "R9 single word block", eob[2], 1);
        pulse_req(4'b0010);
        wait_cyc(8);
        check(xfer_cnt[1] == 2, "R5 second edge", xfer_cnt[1], 2);
        check(eob[1] == 1'b1, "R9 end after two", eob[1], 1);

        // R6 R8 normal output handshake
        load_ch(0, 16'h0400, 3, 1'b1);
        pulse_req(4'b0001);
        wait_cyc(8);
        check(xfer_cnt[0] == 1, "R6 first output word", xfer_cnt[0], 1);
        pulse_req(4'b0001);
        wait_cyc(8);
        check(xfer_cnt[0] == 1, "R6 edge ignored before accept", xfer_cnt[0], 1);
        pulse_ack(4'b0001);
        pulse_req(4'b0001);
        wait_cyc(8);
        check(xfer_cnt[0] == 2, "R6 after accept", xfer_cnt[0], 2);
        pulse_ack(4'b0001);
        pulse_req(4'b0001);
        wait_cyc(8);
        check(xfer_cnt[0] == 3, "R6 third word", xfer_cnt[0], 3);
        check(eob[0] == 1'b1, "R9 output block end", eob[0], 1);

        // R7 maximum-rate mode
        dev_fast[2] = 1'b1;
        load_ch(2, 16'h0500, 5, 1'b1);
        pulse_req(4'b0100);
        dev_fast[2] = 1'b0;
        wait_cyc(30);
        check(xfer_cnt[2] == 5, "R7 fast output runs block", xfer_cnt[2], 5);
        check(eob[2] == 1'b1, "R7 fast block end", eob[2], 1);
        dev_fast[1] = 1'b1;
        load_ch(1, 16'h0600, 3, 1'b0);
        pulse_req(4'b0010);
        wait_cyc(15);
        dev_fast[1] = 1'b0;
        check(xfer_cnt[1] == 1, "R7 fast ignored for input", xfer_cnt[1], 1);
        load_ch(3, 16'h0680, 3, 1'b1);
        pulse_req(4'b1000);
        dev_fast[3] = 1'b1;
        wait_cyc(15);
        dev_fast[3] = 1'b0;
        check(xfer_cnt[3] == 1, "R7 late fast not sampled", xfer_cnt[3], 1);

        // R13 load ignored while the cycle runs
        hold_lat = 1;
        load_ch(0, 16'h0800, 2, 1'b0);
        pulse_req(4'b0001);
        do @(negedge clk); while (!(mem_req && mem_chan_gnt[0]));
        ld_sel = 4'b0001; ld_addr = 16'h0F00; ld_count = CW'(9); ld_out = 1'b1;
        @(negedge clk);
        ld_sel = '0;
        hold_lat = 0;
        wait_cyc(10);
        check(xfer_cnt[0] == 1, "R13 busy load first word", xfer_cnt[0], 1);
        check(eob[0] == 1'b0, "R13 count kept", eob[0], 0);
        pulse_req(4'b0001);
        wait_cyc(10);
        check(xfer_cnt[0] == 2, "R13 original count used", xfer_cnt[0], 2);
        check(eob[0] == 1'b1, "R13 end with original count", eob[0], 1);

        // Random rounds: R4 R9 totals under mixed traffic
        for (int r = 0; r < 6; r++) begin
            dev_req = '0; dev_ack = '0;
            dev_fast = NCH'($urandom);
            for (int c = 0; c < NCH; c++)
                load_ch(c, AW'($urandom), $urandom_range(1, 6), 1'($urandom));
            for (int k = 0; k < 600; k++) begin
                @(negedge clk);
                dev_req   = NCH'($urandom);
                dev_ack   = NCH'($urandom);
                cpu_req   = ($urandom_range(0, 3) == 0);
                mem_avail = ($urandom_range(0, 3) != 0);
                if (&eob) break;
            end
            dev_req = '0; cpu_req = 1'b0; mem_avail = 1'b1;
            wait_cyc(10);
            for (int c = 0; c < NCH; c++) begin
                check(xfer_cnt[c] == load_cnt[c], "R4 words per block", xfer_cnt[c], load_cnt[c]);
                check(eob[c] == 1'b1, "R9 eob at block end", eob[c], 1);
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule